// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, grouped into register sets of 32 pins each. Software picks the direction of each pin, drives output pins high or low through separate write-one-to-set and write-one-to-clear words, and reads back both the driven value and the sampled pin level. Every pin level passes through a two-flop synchronizer before it is visible to software or to the edge detector.

A rising or falling transition on a pin, when that edge is enabled for the pin, latches a bit in the register set's status word. Software clears status bits by writing ones. Each 16-pin half of a register set owns one interrupt line, and a global group-enable word gates every line. The register bus is a plain strobe interface: writes take effect on the clock edge where the write strobe is high, and read data appears in a register one cycle after the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (direction word reads 0xFFFFFFFF, pin_oe_o all 0), and output data, edge enables, status, group enables and irq_o are all 0.
- R2: Direction word (set offset 0x00): bit = 1 makes the pin an input, bit = 0 makes it a driven output; pin_oe_o is the inverse of the direction bit and the word reads back as written.
- R3: Writing a mask to the set-data word (offset 0x08) drives those pins high and to the clear-data word (offset 0x0C) drives them low; zero mask bits change nothing. The output word (offset 0x04) and both set/clear data words read the current driven value, which also appears on pin_o.
- R4: The input word (offset 0x10) shows the pin level after two synchronizer flops, regardless of direction; a read whose address is presented in the same cycle that the pin changes returns the old level, and a read three cycles later returns the new one.
- R5: Writing ones to rise-enable-set (0x14) or fall-enable-set (0x1C) enables that edge for those pins; ones written to rise-enable-clear (0x18) or fall-enable-clear (0x20) disable it. Both words of a pair read the current enable mask.
- R6: An enabled edge, found by comparing the synchronized sample with the previous one, sets the pin's bit in the status word (0x24) three clock edges after the pin changes; a disabled edge sets nothing.
- R7: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R8: If an enabled edge is detected in the same cycle that software writes 1 to clear that status bit, the bit stays set.
- R9: Register set k maps pins 0-15 to group 2k and pins 16-31 to group 2k+1; irq_o[g] is 1 exactly while bit g of the group-enable word is 1 and that 16-bit half of status is nonzero.
- R10: The group-enable word sits at offset 0x08 and reads back its value; register set k starts at 0x10 + k*0x28; every other offset reads 0.
- R11: Read data is registered: bus_rdata_o changes only on the clock edge after the address is presented and reflects a write made on the preceding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_i | input | NUM_PINS | Pin levels from the pads |
| pin_o | output | NUM_PINS | Driven output values |
| pin_oe_o | output | NUM_PINS | Output enables, 1 = drive |
| irq_o | output | NUM_PINS/16 | Per-group interrupt lines |

## Verification
The edge path is swept one pin at a time over all 64 pins with only rising edges enabled, so a misrouted status bit, a wrong set index or a wrong group line shows as a different one-hot value. All pins then fall together with only falling edges enabled, which separates the two enable masks and fills every group at once for the gating and partial-clear cases. A reset sweep over the full address space tells mapped words from holes, and timed pin and write stimuli pin down synchronizer latency, read latency and the clear-versus-edge collision.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int SET_PINS   = 32;
  localparam int GRP_PINS   = 16;
  localparam int SET_BASE   = 'h10;
  localparam int SET_STRIDE = 'h28;
  localparam int GEN_ADDR   = 'h08;

  typedef enum logic [3:0] {
    W_DIR      = 4'd0,
    W_OUT      = 4'd1,
    W_OUT_SET  = 4'd2,
    W_OUT_CLR  = 4'd3,
    W_IN       = 4'd4,
    W_RISE_SET = 4'd5,
    W_RISE_CLR = 4'd6,
    W_FALL_SET = 4'd7,
    W_FALL_CLR = 4'd8,
    W_STAT     = 4'd9
  } word_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
  import gpio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  word_e               word_i,
  input  logic [31:0]         wdata_i,
  input  logic [SET_PINS-1:0] pin_i,
  output logic [31:0]         rdata_o,
  output logic [SET_PINS-1:0] dout_o,
  output logic [SET_PINS-1:0] oe_o,
  output logic [SET_PINS-1:0] stat_o
);
  logic [SET_PINS-1:0] dir_q, dout_q, rise_q, fall_q, stat_q;
  logic [SET_PINS-1:0] samp, prev_q, edge_vec;
  logic wr;

  assign wr = sel_i && we_i;

  gpio_sync #(.WIDTH(SET_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (samp)
  );

  assign edge_vec = (samp & ~prev_q & rise_q) | (~samp & prev_q & fall_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= samp;
      if (wr && word_i == W_DIR)      dir_q  <= wdata_i;
      if (wr && word_i == W_OUT_SET)  dout_q <= dout_q | wdata_i;
      if (wr && word_i == W_OUT_CLR)  dout_q <= dout_q & ~wdata_i;
      if (wr && word_i == W_RISE_SET) rise_q <= rise_q | wdata_i;
      if (wr && word_i == W_RISE_CLR) rise_q <= rise_q & ~wdata_i;
      if (wr && word_i == W_FALL_SET) fall_q <= fall_q | wdata_i;
      if (wr && word_i == W_FALL_CLR) fall_q <= fall_q & ~wdata_i;
      // new edge wins over a simultaneous clear
      stat_q <= (stat_q & ~((wr && word_i == W_STAT) ? wdata_i : '0)) | edge_vec;
    end
  end

  always_comb begin
    unique case (word_i)
      W_DIR:                            rdata_o = dir_q;
      W_OUT, W_OUT_SET, W_OUT_CLR:      rdata_o = dout_q;
      W_IN:                             rdata_o = samp;
      W_RISE_SET, W_RISE_CLR:           rdata_o = rise_q;
      W_FALL_SET, W_FALL_CLR:           rdata_o = fall_q;
      W_STAT:                           rdata_o = stat_q;
      default:                          rdata_o = '0;
    endcase
  end

  assign dout_o = dout_q;
  assign oe_o   = ~dir_q;
  assign stat_o = stat_q;

  assert_dir_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word_i == W_DIR) |=> (oe_o == ~$past(wdata_i)));

  assert_set_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word_i == W_OUT_SET) |=> ((dout_o & $past(wdata_i)) == $past(wdata_i)));

  assert_stat_needs_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_vec == '0) |=> ((stat_o & ~$past(stat_o)) == '0));

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word_i == W_STAT) |=> ((stat_o & $past(wdata_i & ~edge_vec)) == '0));

  assert_edge_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_vec != '0) |=> ((stat_o & $past(edge_vec)) == $past(edge_vec)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  input  logic [NUM_PINS-1:0]         pin_i,
  output logic [NUM_PINS-1:0]         pin_o,
  output logic [NUM_PINS-1:0]         pin_oe_o,
  output logic [NUM_PINS/GRP_PINS-1:0] irq_o
);
  localparam int NUM_SETS   = NUM_PINS / SET_PINS;
  localparam int NUM_GROUPS = NUM_PINS / GRP_PINS;

  logic [NUM_SETS-1:0]    hit;
  logic [31:0]            set_rdata [NUM_SETS];
  logic [SET_PINS-1:0]    set_stat  [NUM_SETS];
  logic [NUM_GROUPS-1:0]  gen_q;
  logic [31:0]            rd_next, rdata_q;
  logic                   gen_hit;

  assign gen_hit = (bus_addr_i == ADDR_W'(GEN_ADDR));

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SET_BASE + k * SET_STRIDE);
    logic [ADDR_W-1:0] offs;
    word_e             word;

    assign offs   = bus_addr_i - BASE;
    assign hit[k] = (bus_addr_i >= BASE) && (offs < ADDR_W'(SET_STRIDE)) &&
                    (offs[1:0] == 2'b00);
    assign word   = word_e'(offs[5:2]);

    gpio_regset u_set (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (hit[k]),
      .we_i   (bus_we_i),
      .word_i (word),
      .wdata_i(bus_wdata_i),
      .pin_i  (pin_i[k*SET_PINS +: SET_PINS]),
      .rdata_o(set_rdata[k]),
      .dout_o (pin_o[k*SET_PINS +: SET_PINS]),
      .oe_o   (pin_oe_o[k*SET_PINS +: SET_PINS]),
      .stat_o (set_stat[k])
    );

    assign irq_o[2*k]   = gen_q[2*k]   && (set_stat[k][GRP_PINS-1:0] != '0);
    assign irq_o[2*k+1] = gen_q[2*k+1] && (set_stat[k][SET_PINS-1:GRP_PINS] != '0);
  end

  always_comb begin
    rd_next = '0;
    if (gen_hit) rd_next = 32'(gen_q);
    for (int k = 0; k < NUM_SETS; k++)
      if (hit[k]) rd_next = rd_next | set_rdata[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
      if (bus_we_i && gen_hit) gen_q <= bus_wdata_i[NUM_GROUPS-1:0];
    end
  end

  assign bus_rdata_o = rdata_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq_chk
    assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gen_q[g] |-> !irq_o[g]);
  end

  assert_one_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit, gen_hit}));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pout, poe;
  logic [3:0]  irq;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  function automatic logic [7:0] sa(int k, int w);
    return 8'(16 + k*40 + w*4);
  endfunction

  function automatic logic [31:0] reset_val(int a);
    if (a >= 16 && a < 96) return (((a - 16) % 40) == 0) ? 32'hFFFF_FFFF : 32'h0;
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, last;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 / R10: full address sweep at reset
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 oe", poe[31:0] | poe[63:32], 32'h0);
    for (int a = 0; a < 256; a += 4) begin
      rd(8'(a), v);
      chk((reset_val(a) != 0) ? "R1 dir" : "R10 map", v, reset_val(a));
    end

    // R2 direction
    wr(sa(0,0), 32'h0000_FFFF);
    chk("R2 oe", poe[31:0], 32'hFFFF_0000);
    rd(sa(0,0), v); chk("R2 readback", v, 32'h0000_FFFF);
    // R11 registered read: previous value held until the clock
    last = rdata;
    addr = sa(1,0); #1;
    chk("R11 hold", rdata, last);
    @(posedge clk); @(negedge clk);
    chk("R11 update", rdata, 32'hFFFF_FFFF);
    wr(sa(1,0), 32'h1234_5678);
    rd(sa(1,0), v); chk("R11 after write", v, 32'h1234_5678);
    chk("R2 oe set1", poe[63:32], ~32'h1234_5678);

    // R3 set / clear data
    wr(sa(0,2), 32'hF0F0_0001);
    rd(sa(0,1), v); chk("R3 out", v, 32'hF0F0_0001);
    chk("R3 pin_o", pout[31:0], 32'hF0F0_0001);
    wr(sa(0,3), 32'h00F0_0001);
    rd(sa(0,1), v); chk("R3 clr", v, 32'hF000_0000);
    wr(sa(0,2), 32'h0);
    wr(sa(0,3), 32'h0);
    rd(sa(0,2), v); chk("R3 zero mask set-word", v, 32'hF000_0000);
    rd(sa(0,3), v); chk("R3 clr-word read", v, 32'hF000_0000);
    for (int b = 0; b < 32; b += 5) begin
      wr(sa(1,2), 32'(1) << b);
      chk("R3 set1 pin", pout[63:32], 32'(1) << b);
      wr(sa(1,3), 32'(1) << b);
      chk("R3 clr1 pin", pout[63:32], 32'h0);
    end

    // R4 input synchronizer latency
    pins[63:32] = 32'hA5A5_0F0F;
    rd(sa(1,4), v); chk("R4 old level", v, 32'h0);
    idle(2);
    rd(sa(1,4), v); chk("R4 new level", v, 32'hA5A5_0F0F);
    pins[31:0] = 32'hFFFF_0000;   // includes pins driven as outputs
    idle(3);
    rd(sa(0,4), v); chk("R4 output pin visible", v, 32'hFFFF_0000);
    pins = '0;
    idle(4);

    // R5 / R6 rising sweep over every pin
    wr(sa(0,5), 32'hFFFF_FFFF);
    wr(sa(1,5), 32'hFFFF_FFFF);
    wr(8'h08, 32'hF);
    rd(sa(0,6), v); chk("R5 clr word reads mask", v, 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) begin
      pins[p] = 1'b1;
      idle(4);
      rd(sa(p/32, 9), v); chk("R6 rise status", v, 32'(1) << (p % 32));
      chk("R9 group line", 32'(irq), 32'(1) << (p / 16));
      wr(sa(p/32, 9), 32'(1) << (p % 32));
      pins[p] = 1'b0;
      idle(4);
      rd(sa(p/32, 9), v); chk("R6 disabled fall", v, 32'h0);
      chk("R9 idle", 32'(irq), 32'h0);
    end

    // R5 falling only
    wr(sa(0,6), 32'hFFFF_FFFF);
    wr(sa(1,6), 32'hFFFF_FFFF);
    wr(sa(0,7), 32'hFFFF_FFFF);
    wr(sa(1,7), 32'hFFFF_FFFF);
    rd(sa(0,5), v); chk("R5 rise cleared", v, 32'h0);
    rd(sa(1,8), v); chk("R5 fall mask", v, 32'hFFFF_FFFF);
    pins = '1;
    idle(4);
    rd(sa(0,9), v); chk("R6 rise disabled", v, 32'h0);
    rd(sa(1,9), v); chk("R6 rise disabled 1", v, 32'h0);
    pins = '0;
    idle(4);
    rd(sa(0,9), v); chk("R6 fall status", v, 32'hFFFF_FFFF);
    rd(sa(1,9), v); chk("R6 fall status 1", v, 32'hFFFF_FFFF);
    chk("R9 all groups", 32'(irq), 32'hF);

    // R7 write-one-to-clear
    wr(sa(0,9), 32'h0);
    rd(sa(0,9), v); chk("R7 zero no effect", v, 32'hFFFF_FFFF);
    wr(sa(0,9), 32'h0000_FFFF);
    rd(sa(0,9), v); chk("R7 partial clear", v, 32'hFFFF_0000);
    chk("R9 group 0 quiet", 32'(irq), 32'hE);

    // R9 / R10 gating
    wr(8'h08, 32'h4);
    chk("R9 gated", 32'(irq), 32'h4);
    rd(8'h08, v); chk("R10 gen readback", v, 32'h4);
    wr(8'h08, 32'h0);
    chk("R9 all gated", 32'(irq), 32'h0);
    wr(sa(0,9), 32'hFFFF_FFFF);
    wr(sa(1,9), 32'hFFFF_FFFF);
    rd(sa(1,9), v); chk("R7 full clear", v, 32'h0);

    // R8 edge beats simultaneous clear
    wr(sa(0,5), 32'h8);
    pins[3] = 1'b1;
    idle(4);
    rd(sa(0,9), v); chk("R8 setup", v, 32'h8);
    pins[3] = 1'b0;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    wr(sa(0,9), 32'h8);
    rd(sa(0,9), v); chk("R8 edge wins", v, 32'h8);
    idle(2);
    wr(sa(0,9), 32'h8);
    rd(sa(0,9), v); chk("R8 later clear", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule